// File: doc/BRIEF.md
# Frame Alignment Measurement Unit

This block measures how late a frame evaluation input arrives relative to the frame pulse of a serial time-slot bus. Software arms a measurement through a start bit. That bit must first have been low across a full frame. When it then rises, the block waits for the next reference frame edge and counts in half master-clock steps until the matching edge of the evaluation input. At the frame edge after that, it publishes the count and a completion flag in a readable alignment word.

The edge polarity follows the bus format. In ST-BUS mode both signals are compared on their falling edges. In GCI mode both are compared on their rising edges. Both clock edges are used for sampling, so the result resolves half a clock period. The result and the flag stay valid until software drives the start bit low again, which clears them and makes a new cycle possible.

Top module: `frame_align_meter`

## Requirements
- R1: After reset, the alignment word reads all zeros.
- R2: Bits 11..0 of the alignment word hold the measured offset, bit 12 is the completion flag, and bits 15..13 always read zero.
- R3: With `gci_mode`=0 the falling edges of both `frame_pulse` and `eval_in` are used. With `gci_mode`=1 the rising edges of both are used. Edges of the other direction are never used.
- R4: The offset is the number of half master-clock periods from the reference frame edge to the first matching evaluation edge within that frame. An evaluation edge seen in the same half-period sample as the frame edge gives 0.
- R5: A rise of `start_bit` begins a measurement only if the start bit was low while at least two reference frame edges occurred. Any other rise is ignored, and the word stays zero until the start bit has gone low and has requalified.
- R6: After an accepted rise, the first reference frame edge opens the measured frame. The completion flag and the result appear together at the second reference frame edge, and not before it.
- R7: In the clock cycle after `start_bit` is sampled low, the alignment word reads zero.
- R8: The offset saturates at 4095. If no matching evaluation edge occurs inside the measured frame, the result is 4095.
- R9: While the flag is set, the result does not change, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; both of its edges sample the serial inputs |
| rst | input | 1 | Synchronous active-high reset |
| frame_pulse | input | 1 | Frame synchronisation pulse |
| eval_in | input | 1 | Frame evaluation signal whose delay is measured |
| start_bit | input | 1 | Control bit that arms a measurement on its rising edge |
| gci_mode | input | 1 | 0 selects ST-BUS falling-edge timing, 1 selects GCI rising-edge timing |
| align_word | output | 16 | Alignment register value: offset in bits 11..0, completion flag in bit 12 |

## Verification
The evaluation edge is placed at even and odd half-clock offsets in both bus formats, including the offset of zero where the evaluation edge coincides with the frame edge. The evaluation pulse is kept wider than the frame pulse, so a design that compared the wrong edge direction would report a value that is off by three. A frame with no evaluation edge and a frame longer than the 12-bit range check the saturated value 4095. Directed cases cover a start rise without a full low frame, a check just before the closing frame edge (which tells a late flag from an early one), changed inputs while the flag is held, and the clear on a low start bit.

// File: rtl/fam_pkg.sv
package fam_pkg;

    localparam int RES_W       = 12;
    localparam int WORD_W      = 16;
    localparam int FLAG_POS    = RES_W;
    localparam int QUAL_FRAMES = 2;
    localparam int QUAL_W      = $clog2(QUAL_FRAMES + 1);
    localparam int LANES       = 2;
    localparam int LANE_FP     = 0;
    localparam int LANE_EV     = 1;

    typedef logic [RES_W-1:0] offs_t;

    // hit: an edge was seen in this cycle; half: 0 = in the falling-edge sample, 1 = in the rising-edge sample
    typedef struct packed {
        logic hit;
        logic half;
    } edge_evt_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_REF,
        ST_COUNT,
        ST_DONE
    } meas_state_t;

    // Edge search over three consecutive half-period samples
    function automatic edge_evt_t find_edge(input logic prev_s, input logic mid_s,
                                            input logic cur_s, input logic rising);
        edge_evt_t r;
        logic e_first;
        logic e_second;
        if (rising) begin
            e_first  = !prev_s && mid_s;
            e_second = !mid_s && cur_s;
        end else begin
            e_first  = prev_s && !mid_s;
            e_second = mid_s && !cur_s;
        end
        r.hit  = e_first || e_second;
        r.half = !e_first && e_second;
        return r;
    endfunction

    function automatic offs_t sat_add(input offs_t a, input logic [1:0] inc);
        logic [RES_W:0] s;
        s = {1'b0, a} + {{(RES_W-1){1'b0}}, inc};
        return s[RES_W] ? {RES_W{1'b1}} : s[RES_W-1:0];
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input logic flag, input offs_t res);
        logic [WORD_W-1:0] w;
        w = '0;
        w[RES_W-1:0] = res;
        w[FLAG_POS]  = flag;
        return w;
    endfunction

endpackage

// File: rtl/fam_half_sampler.sv
module fam_half_sampler
    import fam_pkg::*;
#(
    parameter int N_LANES = LANES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 gci_mode,
    input  logic [N_LANES-1:0]   lines,
    output edge_evt_t [N_LANES-1:0] evts
);

    logic idle_lvl;
    assign idle_lvl = !gci_mode;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        logic neg_q;
        logic neg_hold_q;
        logic pos_q;
        logic prev_q;

        // Falling-edge sample of the line
        always_ff @(negedge clk) begin
            if (rst) neg_q <= idle_lvl;
            else     neg_q <= lines[g];
        end

        // Rising-edge samples, realigned so one cycle yields an ordered triple
        always_ff @(posedge clk) begin
            if (rst) begin
                neg_hold_q <= idle_lvl;
                pos_q      <= idle_lvl;
                prev_q     <= idle_lvl;
            end else begin
                neg_hold_q <= neg_q;
                pos_q      <= lines[g];
                prev_q     <= pos_q;
            end
        end

        assign evts[g] = find_edge(prev_q, neg_hold_q, pos_q, gci_mode);
    end

endmodule

// File: rtl/fam_arm_seq.sv
module fam_arm_seq
    import fam_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_bit,
    input  edge_evt_t   fr_evt,
    output meas_state_t state_q
);

    logic              start_q;
    logic [QUAL_W-1:0] qual_q;
    logic              qual_full;
    logic              start_rise;
    meas_state_t       state_d;

    assign qual_full  = (qual_q == QUAL_W'(QUAL_FRAMES));
    assign start_rise = start_bit && !start_q;

    always_comb begin
        state_d = state_q;
        if (!start_bit) begin
            state_d = ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:     if (start_rise && qual_full) state_d = ST_WAIT_REF;
                ST_WAIT_REF: if (fr_evt.hit) state_d = ST_COUNT;
                ST_COUNT:    if (fr_evt.hit) state_d = ST_DONE;
                ST_DONE:     state_d = ST_DONE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            qual_q  <= '0;
            state_q <= ST_IDLE;
        end else begin
            start_q <= start_bit;
            state_q <= state_d;
            if (start_bit)                     qual_q <= '0;
            else if (fr_evt.hit && !qual_full) qual_q <= qual_q + 1'b1;
        end
    end

    // R5: a measurement is armed only after a qualified low period
    a_r5_arm_needs_qual: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_REF && $past(state_q) == ST_IDLE) |-> $past(qual_q == QUAL_W'(QUAL_FRAMES)));

    // R6: completion is reached only from the counting state at a frame edge
    a_r6_done_after_count: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE && $past(state_q) != ST_DONE) |-> ($past(state_q) == ST_COUNT && $past(fr_evt.hit)));

endmodule

// File: rtl/fam_offset_track.sv
module fam_offset_track
    import fam_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_bit,
    input  meas_state_t state_q,
    input  edge_evt_t   fr_evt,
    input  edge_evt_t   ev_evt,
    output offs_t       result_q
);

    offs_t cnt_q,  cnt_d;
    offs_t capv_q, capv_d;
    logic  cap_q,  cap_d;
    offs_t result_d;
    logic  ev_ok;
    offs_t ev_off;

    // Count at the falling sample is cnt+1, at the rising sample cnt+2
    assign ev_off = sat_add(cnt_q, {1'b0, 1'b1} + {1'b0, ev_evt.half});
    assign ev_ok  = ev_evt.hit && !cap_q && (!fr_evt.hit || (ev_evt.half < fr_evt.half));

    always_comb begin
        cnt_d    = cnt_q;
        capv_d   = capv_q;
        cap_d    = cap_q;
        result_d = result_q;
        case (state_q)
            ST_IDLE: begin
                cnt_d  = '0;
                cap_d  = 1'b0;
                capv_d = '0;
            end
            ST_WAIT_REF: begin
                if (fr_evt.hit) begin
                    cnt_d = offs_t'(!fr_evt.half);
                    if (ev_evt.hit && (ev_evt.half >= fr_evt.half)) begin
                        cap_d  = 1'b1;
                        capv_d = offs_t'(ev_evt.half && !fr_evt.half);
                    end
                end
            end
            ST_COUNT: begin
                if (fr_evt.hit) begin
                    result_d = cap_q ? capv_q : (ev_ok ? ev_off : {RES_W{1'b1}});
                end else begin
                    cnt_d = sat_add(cnt_q, 2'd2);
                    if (ev_ok) begin
                        cap_d  = 1'b1;
                        capv_d = ev_off;
                    end
                end
            end
            default: ;
        endcase
        if (!start_bit) begin
            result_d = '0;
            cap_d    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            capv_q   <= '0;
            cap_q    <= 1'b0;
            result_q <= '0;
        end else begin
            cnt_q    <= cnt_d;
            capv_q   <= capv_d;
            cap_q    <= cap_d;
            result_q <= result_d;
        end
    end

    // R8: the half-period counter holds at its ceiling
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COUNT && start_bit && !fr_evt.hit && cnt_q == {RES_W{1'b1}}) |=> (cnt_q == {RES_W{1'b1}}));

    // R9: the published result is frozen while complete
    a_r9_result_held: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE && $past(state_q) == ST_DONE) |-> $stable(result_q));

endmodule

// File: rtl/frame_align_meter.sv
module frame_align_meter
    import fam_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_pulse,
    input  logic        eval_in,
    input  logic        start_bit,
    input  logic        gci_mode,
    output logic [15:0] align_word
);

    edge_evt_t [LANES-1:0] evts;
    meas_state_t           state_q;
    offs_t                 result_q;
    logic [LANES-1:0]      lines;

    always_comb begin
        lines          = '0;
        lines[LANE_FP] = frame_pulse;
        lines[LANE_EV] = eval_in;
    end

    fam_half_sampler #(.N_LANES(LANES)) u_sampler (
        .clk      (clk),
        .rst      (rst),
        .gci_mode (gci_mode),
        .lines    (lines),
        .evts     (evts)
    );

    fam_arm_seq u_arm (
        .clk       (clk),
        .rst       (rst),
        .start_bit (start_bit),
        .fr_evt    (evts[LANE_FP]),
        .state_q   (state_q)
    );

    fam_offset_track u_track (
        .clk       (clk),
        .rst       (rst),
        .start_bit (start_bit),
        .state_q   (state_q),
        .fr_evt    (evts[LANE_FP]),
        .ev_evt    (evts[LANE_EV]),
        .result_q  (result_q)
    );

    assign align_word = pack_word(state_q == ST_DONE, result_q);

    // R7: a low start bit clears the word on the next cycle
    a_r7_clear_on_low: assert property (@(posedge clk) disable iff (rst)
        !start_bit |=> (align_word == '0));

    // R5: the flag is never shown unless the start bit was high
    a_r5_flag_needs_start: assert property (@(posedge clk) disable iff (rst)
        align_word[FLAG_POS] |-> $past(start_bit));

endmodule

// File: tb/frame_align_meter_bench.sv
module frame_align_meter_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        frame_pulse;
    logic        eval_in;
    logic        start_bit;
    logic        gci_mode;
    logic [15:0] align_word;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = !clk;

    frame_align_meter u_frame_align_meter (
        .clk         (clk),
        .rst         (rst),
        .frame_pulse (frame_pulse),
        .eval_in     (eval_in),
        .start_bit   (start_bit),
        .gci_mode    (gci_mode),
        .align_word  (align_word)
    );

    // Vectors: {gci_mode, frame length in half periods, evaluation edge slot}
    localparam int NVEC = 8;
    localparam int VEC [NVEC][3] = '{
        '{0, 40, 0},
        '{0, 40, 1},
        '{0, 40, 7},
        '{1, 40, 0},
        '{1, 40, 3},
        '{1, 60, 20},
        '{0, 60, 37},
        '{1, 30, 21}
    };

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // Ends 5 ns after the next clock edge of either direction
    task automatic half_step();
        @(clk);
        #5;
    endtask

    // Frame pulse active for 2 half periods from slot 0, evaluation active for 5 from slot d
    task automatic run_frame(input int len, input int d);
        logic idle_l;
        idle_l = !gci_mode;
        for (int s = 0; s < len; s++) begin
            frame_pulse = (s < 2) ? !idle_l : idle_l;
            eval_in     = (d >= 0 && s >= d && s < d + 5) ? !idle_l : idle_l;
            half_step();
        end
    endtask

    logic [15:0] mid_word;

    task automatic do_measure(input logic g, input int len, input int d);
        start_bit = 1'b0;
        gci_mode  = g;
        frame_pulse = !g;
        eval_in     = !g;
        half_step();
        half_step();
        repeat (3) run_frame(len, -1);
        start_bit = 1'b1;
        run_frame(len, d);
        mid_word = align_word;
        run_frame(len, -1);
    endtask

    task automatic clear_start();
        start_bit = 1'b0;
        repeat (4) half_step();
    endtask

    function automatic logic [15:0] done_word(input int v);
        logic [15:0] w;
        w = 16'h1000;
        w[11:0] = (v > 4095) ? 12'hFFF : v[11:0];
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        frame_pulse = 1'b1;
        eval_in = 1'b1;
        start_bit = 1'b0;
        gci_mode = 1'b0;
        repeat (4) @(posedge clk);
        #5;
        rst = 1'b0;
        half_step();
        check("R1 reset word", align_word, 16'h0000);

        // Table walk: R3 R4 R2 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            do_measure(VEC[i][0][0], VEC[i][1], VEC[i][2]);
            check("R6 no flag before closing edge", mid_word, 16'h0000);
            check("R4 R3 R2 offset and flag", align_word, done_word(VEC[i][2]));
            clear_start();
            check("R7 clear on low start", align_word, 16'h0000);
        end

        // R8: no evaluation edge inside the measured frame
        do_measure(1'b1, 40, -1);
        check("R8 missing edge saturates", align_word, 16'h1FFF);
        clear_start();

        // R8: offset beyond 12-bit range
        do_measure(1'b0, 4300, 4200);
        check("R8 long offset saturates", align_word, 16'h1FFF);

        // R9: result frozen while flag held
        run_frame(4300, 9);
        run_frame(40, 3);
        check("R9 held result", align_word, 16'h1FFF);
        clear_start();
        check("R7 clear after hold", align_word, 16'h0000);

        // R5: rise without a full low frame is ignored
        start_bit = 1'b1;
        gci_mode = 1'b0;
        repeat (3) run_frame(40, 5);
        check("R5 unqualified rise ignored", align_word, 16'h0000);
        clear_start();
        do_measure(1'b0, 40, 11);
        check("R5 requalified measurement", align_word, done_word(11));
        clear_start();

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule